// File: doc/BRIEF.md
# Two-Register Byte Processor

This block is a single-cycle 8-bit processor. It keeps two 8-bit working registers and a program counter, and it reads instructions and data through two separate memory ports. On every rising clock edge it retires the single byte-wide instruction found at the program counter. The instruction and data memories sit outside the block. The instruction port and the data read port are asynchronous: the address goes out and the data comes back within the same cycle.

The three most significant bits of each instruction select its class. The classes are:

- a register-register group with four ALU operations;
- a load from data memory and a store to data memory, each using a 4-bit address;
- a load of a nibble into the upper half of a register;
- an OR of a nibble into the lower half of a register;
- a jump that rewrites only the low five bits of the program counter;
- a branch that is taken when the two registers hold equal values.

A jump to its own address parks the processor and serves as a halt.

Top module: `duo_cpu`

## Requirements
- R1: A synchronous reset clears the program counter and both registers to zero, and it holds `imemAddr` at 0 for as long as reset is asserted.
- R2: When bits 7:5 are 000, bits 4:3 select the operation: 00 or, 01 add, 10 and, 11 sub. The result is written to the register named by bit 2. The first operand comes from the register named by bit 1 and the second operand from the register named by bit 0. Sub computes first minus second.
- R3: When bits 7:5 are 001, the register named by bit 4 is loaded from data memory at the address in bits 3:0.
- R4: When bits 7:5 are 010, the register named by bit 4 is written to data memory at the address in bits 3:0. `dmemWe` is high only for this instruction class and never while reset is asserted.
- R5: When bits 7:5 are 011, the register named by bit 4 receives the value in bits 3:0 in its upper nibble and zero in its lower nibble. The other register is left unchanged.
- R6: When bits 7:5 are 100, the value in bits 3:0, zero-extended, is ORed into the register named by bit 4. The other register is left unchanged.
- R7: When bits 7:5 are 101, the next program counter keeps its own bits 7:5 and takes bits 4:0 of the instruction as its low five bits. A jump to its own address holds the program counter there.
- R8: When bits 7:5 are 110, the branch compares register 0 with register 1. If they are equal, the next program counter is PC + 1 plus bits 4:0 sign-extended, modulo 256. If they differ, it is PC + 1.
- R9: Every instruction other than a jump or a branch advances the program counter by one, modulo 256. Opcode 111 does nothing else.
- R10: Register arithmetic wraps modulo 256 and raises no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| imemAddr | output | 8 | Program counter, used as the instruction fetch address |
| imemData | input | 8 | Instruction byte at `imemAddr` |
| dmemAddr | output | 8 | Data address, the zero-extended 4-bit immediate |
| dmemWdata | output | 8 | Store data |
| dmemRdata | input | 8 | Load data at `dmemAddr` |
| dmemWe | output | 1 | Store strobe; memory writes on the rising edge |

## Verification
The bench sweeps all four ALU operations over a 16x16 grid of operand values, with the register-select bits varied. A design that swapped the operand fields or used the wrong subtraction order would store the wrong difference. It also sweeps every branch offset from -16 to +15 with equal and unequal registers, starting close enough to address 0 that negative offsets wrap to the top of memory. A design that failed to sign-extend the offset, or that measured it from the branch itself, would land on the wrong address. A jump is executed from above address 0x1F: a design that replaced the whole program counter would fall back into the low code and never reach its marker store. Stores and loads run across all sixteen addresses, and the bench counts write strobes, so a stray `dmemWe` on another instruction class shows up as an extra write.

// File: rtl/duo_cpu_pkg.sv
package duo_cpu_pkg;
  localparam int DATA_W = 8;
  localparam int IMM_W  = 4;
  localparam int JT_W   = 5;
  localparam int NREG   = 2;
  localparam int SEL_W  = $clog2(NREG);

  localparam logic [2:0] OP_RR   = 3'b000;
  localparam logic [2:0] OP_LOAD = 3'b001;
  localparam logic [2:0] OP_STOR = 3'b010;
  localparam logic [2:0] OP_HIGH = 3'b011;
  localparam logic [2:0] OP_ORIM = 3'b100;
  localparam logic [2:0] OP_JUMP = 3'b101;
  localparam logic [2:0] OP_BREQ = 3'b110;

  typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_HIGH, WB_ORIM} wbSel_e;
  typedef enum logic [1:0] {PC_SEQ, PC_JMP, PC_BEQ} pcSel_e;
  typedef enum logic [1:0] {ALU_OR, ALU_ADD, ALU_AND, ALU_SUB} aluOp_e;

  typedef struct packed {
    logic             regWe;
    wbSel_e           wbSel;
    aluOp_e           aluOp;
    logic [SEL_W-1:0] rdSel;
    logic [SEL_W-1:0] raSel;
    logic [SEL_W-1:0] rbSel;
    logic             memWe;
    pcSel_e           pcSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/duo_cpu_ctrl.sv
module duo_cpu_ctrl
  import duo_cpu_pkg::*;
(
  input  logic         rst,
  input  logic [7:0]   instr,
  output ctrlStrobes_t strobes
);
  logic [2:0] major;
  assign major = instr[7:5];

  always_comb begin
    strobes = '0;
    unique case (major)
      OP_RR: begin
        strobes.regWe = 1'b1;
        strobes.wbSel = WB_ALU;
        strobes.aluOp = aluOp_e'(instr[4:3]);
        strobes.rdSel = instr[2];
        strobes.raSel = instr[1];
        strobes.rbSel = instr[0];
      end
      OP_LOAD: begin
        strobes.regWe = 1'b1;
        strobes.wbSel = WB_MEM;
        strobes.rdSel = instr[4];
      end
      OP_STOR: begin
        strobes.memWe = ~rst;
        strobes.raSel = instr[4];
      end
      OP_HIGH: begin
        strobes.regWe = 1'b1;
        strobes.wbSel = WB_HIGH;
        strobes.rdSel = instr[4];
      end
      OP_ORIM: begin
        strobes.regWe = 1'b1;
        strobes.wbSel = WB_ORIM;
        strobes.rdSel = instr[4];
        strobes.raSel = instr[4];
      end
      OP_JUMP: strobes.pcSel = PC_JMP;
      OP_BREQ: begin
        strobes.pcSel = PC_BEQ;
        strobes.raSel = 1'b0;
        strobes.rbSel = 1'b1;
      end
      default: strobes = '0;
    endcase
  end
endmodule

// File: rtl/duo_cpu_datapath.sv
module duo_cpu_datapath
  import duo_cpu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  input  logic [JT_W-1:0]   instrLow,
  output logic [DATA_W-1:0] pc,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  input  logic [DATA_W-1:0] memRdata
);
  localparam int HI_W = DATA_W - IMM_W;
  localparam int PH_W = DATA_W - JT_W;

  logic [DATA_W-1:0] regFile [NREG];
  logic [DATA_W-1:0] opA, opB, aluRes, wbData, pcInc, pcNext, offExt;
  logic [IMM_W-1:0]  imm;

  assign imm      = instrLow[IMM_W-1:0];
  assign opA      = regFile[strobes.raSel];
  assign opB      = regFile[strobes.rbSel];
  assign memAddr  = {{HI_W{1'b0}}, imm};
  assign memWdata = opA;
  assign memWe    = strobes.memWe;
  assign offExt   = {{PH_W{instrLow[JT_W-1]}}, instrLow};
  assign pcInc    = pc + 1'b1;

  always_comb begin
    unique case (strobes.aluOp)
      ALU_OR:  aluRes = opA | opB;
      ALU_ADD: aluRes = opA + opB;
      ALU_AND: aluRes = opA & opB;
      default: aluRes = opA - opB;
    endcase
  end

  always_comb begin
    unique case (strobes.wbSel)
      WB_ALU:  wbData = aluRes;
      WB_MEM:  wbData = memRdata;
      WB_HIGH: wbData = {imm, {HI_W{1'b0}}};
      default: wbData = opA | {{HI_W{1'b0}}, imm};
    endcase
  end

  always_comb begin
    unique case (strobes.pcSel)
      PC_JMP:  pcNext = {pc[DATA_W-1:JT_W], instrLow};
      PC_BEQ:  pcNext = (opA == opB) ? pcInc + offExt : pcInc;
      default: pcNext = pcInc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc      <= '0;
      regFile <= '{default: '0};
    end else begin
      pc <= pcNext;
      if (strobes.regWe) regFile[strobes.rdSel] <= wbData;
    end
  end

  // R1
  reset_pc_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pc == '0));

  // R9
  seq_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.pcSel == PC_SEQ) |=> (pc == $past(pc) + 1'b1));

  // R7
  jump_low_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.pcSel == PC_JMP) |=>
      (pc[DATA_W-1:JT_W] == $past(pc[DATA_W-1:JT_W])) && (pc[JT_W-1:0] == $past(instrLow)));

  // R8
  branch_not_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.pcSel == PC_BEQ && regFile[0] != regFile[1]) |=> (pc == $past(pc) + 1'b1));

  // R3
  load_write_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.regWe && strobes.wbSel == WB_MEM) |=>
      (regFile[$past(strobes.rdSel)] == $past(memRdata)));
endmodule

// File: rtl/duo_cpu.sv
module duo_cpu
  import duo_cpu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  output logic [DATA_W-1:0] imemAddr,
  input  logic [DATA_W-1:0] imemData,
  output logic [DATA_W-1:0] dmemAddr,
  output logic [DATA_W-1:0] dmemWdata,
  input  logic [DATA_W-1:0] dmemRdata,
  output logic              dmemWe
);
  ctrlStrobes_t strobes;

  duo_cpu_ctrl u_ctrl (
    .rst     (rst),
    .instr   (imemData),
    .strobes (strobes)
  );

  duo_cpu_datapath u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .instrLow (imemData[JT_W-1:0]),
    .pc       (imemAddr),
    .memAddr  (dmemAddr),
    .memWdata (dmemWdata),
    .memWe    (dmemWe),
    .memRdata (dmemRdata)
  );

  // R4
  store_only_chk: assert property (@(posedge clk) disable iff (rst)
    dmemWe |-> (imemData[7:5] == OP_STOR));
endmodule

// File: tb/duo_cpu_bench.sv
`timescale 1ns/1ps
module duo_cpu_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] imemAddr, imemData, dmemAddr, dmemWdata, dmemRdata;
  logic dmemWe;

  logic [7:0] imem [256];
  logic [7:0] dmem [16];
  logic [7:0] dmemSeed [16];
  int writeCount;
  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  duo_cpu u_duo_cpu (
    .clk(clk), .rst(rst), .imemAddr(imemAddr), .imemData(imemData),
    .dmemAddr(dmemAddr), .dmemWdata(dmemWdata), .dmemRdata(dmemRdata), .dmemWe(dmemWe)
  );

  assign imemData  = imem[imemAddr];
  assign dmemRdata = dmem[dmemAddr[3:0]];

  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 16; k++) dmem[k] <= dmemSeed[k];
      writeCount <= 0;
    end else if (dmemWe) begin
      dmem[dmemAddr[3:0]] <= dmemWdata;
      writeCount <= writeCount + 1;
    end
  end

  function automatic logic [7:0] encRR(input logic [1:0] op, input logic rd, ra, rb);
    return {3'b000, op, rd, ra, rb};
  endfunction
  function automatic logic [7:0] encI(input logic [2:0] maj, input logic r, input logic [3:0] v);
    return {maj, r, v};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearImem();
    for (int k = 0; k < 256; k++) imem[k] = 8'hE0;
  endtask

  task automatic startRun();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    for (int k = 0; k < 16; k++) dmemSeed[k] = 8'hAA;
    clearImem();
    repeat (3) @(negedge clk);
    // R1: fetch address during reset
    chk("R1 pc in reset", imemAddr, 8'h00);

    // R1: dirty registers, then reset and store both
    imem[0] = encI(3'b011, 1'b0, 4'h9); imem[1] = encI(3'b011, 1'b1, 4'h5);
    imem[2] = 8'hA2;
    startRun(); step(3);
    clearImem();
    imem[0] = encI(3'b010, 1'b0, 4'd3); imem[1] = encI(3'b010, 1'b1, 4'd4); imem[2] = 8'hA2;
    startRun(); step(3);
    chk("R1 r0 after reset", dmem[3], 8'h00);
    chk("R1 r1 after reset", dmem[4], 8'h00);

    // R2/R10 sweep of all ops and field selections
    for (int op = 0; op < 4; op++) begin
      for (int i = 0; i < 16; i++) begin
        for (int j = 0; j < 16; j++) begin
          logic [7:0] a, b, x, y, e;
          logic rd, ra, rb;
          a = 8'(i * 37 + 5); b = 8'(j * 59 + 7);
          rd = 1'((i + j) & 1); ra = 1'(i & 1); rb = 1'(j & 1);
          x = ra ? b : a; y = rb ? b : a;
          case (op)
            0: e = x | y;
            1: e = 8'(x + y);
            2: e = x & y;
            default: e = 8'(x - y);
          endcase
          clearImem();
          imem[0] = encI(3'b011, 1'b0, a[7:4]); imem[1] = encI(3'b100, 1'b0, a[3:0]);
          imem[2] = encI(3'b011, 1'b1, b[7:4]); imem[3] = encI(3'b100, 1'b1, b[3:0]);
          imem[4] = encRR(2'(op), rd, ra, rb);
          imem[5] = encI(3'b010, rd, 4'd2);
          imem[6] = 8'hA6;
          startRun(); step(8);
          chk("R2 R10 alu result", dmem[2], e);
          chk("R4 single write", 8'(writeCount), 8'd1);
          chk("R7 halt holds pc", imemAddr, 8'h06);
        end
      end
    end

    // R5/R6 sweep: lui then two ori, other register untouched
    for (int h = 0; h < 16; h++) begin
      for (int l = 0; l < 16; l++) begin
        logic r;
        logic [3:0] m;
        r = 1'((h + l) & 1); m = 4'(h ^ l);
        clearImem();
        imem[0] = encI(3'b011, r, 4'(h)); imem[1] = encI(3'b010, r, 4'd5);
        imem[2] = encI(3'b100, r, 4'(l)); imem[3] = encI(3'b100, r, m);
        imem[4] = encI(3'b010, r, 4'd3); imem[5] = encI(3'b010, ~r, 4'd4);
        imem[6] = 8'hA6;
        startRun(); step(8);
        chk("R5 upper nibble load", dmem[5], {4'(h), 4'h0});
        chk("R6 or immediate", dmem[3], {4'(h), 4'(l) | m});
        chk("R5 R6 other reg kept", dmem[4], 8'h00);
      end
    end

    // R3/R4 loads and stores over every address
    for (int k = 0; k < 16; k++) dmemSeed[k] = 8'(k * 29 + 1);
    for (int k = 0; k < 16; k++) begin
      logic r;
      r = 1'(k & 1);
      clearImem();
      imem[0] = encI(3'b001, r, 4'(k)); imem[1] = encI(3'b010, r, 4'(k + 1));
      imem[2] = 8'hA2;
      startRun(); step(4);
      chk("R3 load then store", dmem[(k + 1) % 16], 8'(k * 29 + 1));
      chk("R4 write count", 8'(writeCount), 8'd1);
    end
    for (int k = 0; k < 16; k++) dmemSeed[k] = 8'hAA;

    // R9: undefined opcode only advances, wraps at 256
    clearImem();
    startRun(); step(40);
    chk("R9 nop advance", imemAddr, 8'd40);
    step(260);
    chk("R9 pc wrap", imemAddr, 8'd44);
    chk("R4 no writes on nop", 8'(writeCount), 8'd0);

    // R7: jump from above 0x1F keeps upper bits
    clearImem();
    imem[8'h25] = 8'hA8;
    imem[8'h28] = encI(3'b011, 1'b0, 4'h7); imem[8'h29] = encI(3'b010, 1'b0, 4'd1);
    imem[8'h2A] = 8'hAA;
    startRun(); step(45);
    chk("R7 jump marker", dmem[1], 8'h70);
    chk("R7 jump halt pc", imemAddr, 8'h2A);

    // R8: every offset, equal and unequal
    for (int off = -16; off < 16; off++) begin
      for (int eq = 0; eq < 2; eq++) begin
        logic [3:0] v, w;
        v = 4'(off + 16); w = (eq == 1) ? v : v ^ 4'h1;
        clearImem();
        imem[0] = encI(3'b011, 1'b0, v); imem[1] = encI(3'b011, 1'b1, w);
        imem[2] = {3'b110, 5'(off)};
        startRun(); step(3);
        chk("R8 branch target", imemAddr, (eq == 1) ? 8'(3 + off) : 8'd3);
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule